// File: doc/BRIEF.md
# Overlap-Safe Memory Block Copier

The block moves a run of bytes from one place in a byte-addressed memory to another. A caller gives it a source address, a destination address and a byte count, and pulses `start`. The final memory contents always match a loop that copies one byte at a time from the lowest address upward. This holds even when the two ranges overlap. In particular, setting the destination one byte above the source spreads the first source byte over the whole destination range, which is a common way to fill a buffer.

The copy is broken into separate read and write requests on a simple memory port. Only one request is in flight at a time. Every request shows its address, direction and width, so a neighbouring conflict checker can compare other traffic against each access. When source and destination are both word aligned and at least four bytes remain, an access carries a whole little-endian word. In every other case it carries a single byte. Two indicator outputs mark each access that is the first of a copy for its operand, or the first after that operand crosses into a new page. A surrounding unit can use them to start a fresh address translation.

Top module: `blkcopy`

## Requirements
- R1: After a copy completes, every memory byte equals the value produced by copying `len` bytes one at a time in ascending address order, for any overlap or alignment of source and destination.
- R2: With destination equal to source plus one, every destination byte ends up equal to the original byte at the source address.
- R3: An access is a word access (`mem_wide`=1, four bytes, byte k of the word at address+k in bits 8k+7:8k) exactly when the current source and destination are both multiples of 4 and at least 4 bytes remain. Otherwise it is a byte access in bits 7:0. Word accesses always have address bits 1:0 equal to zero.
- R4: Only one request is outstanding at a time. A request holds its address and direction until `mem_ack`. Each write is issued right after the read it pairs with, so reads and writes alternate and their counts are equal.
- R5: A `start` with `len`=0 raises `done` in the next cycle, makes no memory request and leaves `busy` low.
- R6: For a non-zero length, `busy` is high from the cycle after `start` until the final write is acknowledged. `done` is then a single-cycle pulse, during which `busy` is already low.
- R7: `src_page_new` (during reads) and `dst_page_new` (during writes) mark the first access of a copy and every access whose page number differs from that of the previous access to the same operand. Page number = address bits AW-1:PAGE_BITS. Over one copy, the number of marked accesses equals the number of pages the operand's range touches.
- R8: `start` is ignored while `busy` is high.
- R9: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the given operands |
| src | input | AW | Source start address |
| dst | input | AW | Destination start address |
| len | input | LW | Number of bytes to copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Request completes this cycle |
| src_page_new | output | 1 | Read access enters a new source page |
| dst_page_new | output | 1 | Write access enters a new destination page |

## Verification
The bench sweeps every pairing of eight source offsets with sixteen destination offsets, covering backward, forward, disjoint and one- to three-byte overlaps. Each pairing is tried at every length from 0 to 11, and some ranges straddle a page edge. Offset pairs with equal low bits separate correct word use from byte-only behaviour. Small positive destination offsets expose any read that runs ahead of a pending write. The page counts tell a per-page marker apart from one that fires once or on every access. Separate runs exercise the fill idiom, a start pulse issued mid-copy, and the zero-length case.

// File: rtl/blkcopy.sv
module blkcopy #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          src_page_new,
  output logic          dst_page_new
);
  typedef enum logic [1:0] {IDLE, RD, WR} state_t;

  state_t        st;
  logic [AW-1:0] s, d;
  logic [LW-1:0] rem;
  logic [31:0]   hold;
  logic          done_r, spn, dpn;

  logic          wide;
  logic [AW-1:0] step_a, s_nx, d_nx;
  logic [LW-1:0] step_l;

  assign wide   = (s[1:0] == 2'b00) && (d[1:0] == 2'b00) && (rem >= LW'(4));
  assign step_a = wide ? AW'(4) : AW'(1);
  assign step_l = wide ? LW'(4) : LW'(1);
  assign s_nx   = s + step_a;
  assign d_nx   = d + step_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      s      <= '0;
      d      <= '0;
      rem    <= '0;
      hold   <= '0;
      done_r <= 1'b0;
      spn    <= 1'b0;
      dpn    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (len == '0) done_r <= 1'b1;
          else begin
            s   <= src;
            d   <= dst;
            rem <= len;
            spn <= 1'b1;
            dpn <= 1'b1;
            st  <= RD;
          end
        end
        RD: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= WR;
        end
        WR: if (mem_ack) begin
          s   <= s_nx;
          d   <= d_nx;
          rem <= rem - step_l;
          spn <= s_nx[AW-1:PAGE_BITS] != s[AW-1:PAGE_BITS];
          dpn <= d_nx[AW-1:PAGE_BITS] != d[AW-1:PAGE_BITS];
          if (rem == step_l) begin
            st     <= IDLE;
            done_r <= 1'b1;
          end else st <= RD;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy         = st != IDLE;
  assign done         = done_r;
  assign mem_req      = st != IDLE;
  assign mem_we       = st == WR;
  assign mem_wide     = wide;
  assign mem_addr     = (st == WR) ? d : s;
  assign mem_wdata    = wide ? hold : {24'b0, hold[7:0]};
  assign src_page_new = (st == RD) && spn;
  assign dst_page_new = (st == WR) && dpn;
endmodule

module blkcopy_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_wide,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          src_page_new,
  input logic          dst_page_new
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> mem_req && mem_we); // R4
  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wide |-> mem_addr[1:0] == 2'b00); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req); // R6
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R6
  AST_SRC_PAGE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    src_page_new |-> mem_req && !mem_we); // R7
  AST_DST_PAGE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_page_new |-> mem_req && mem_we); // R7
endmodule

bind blkcopy blkcopy_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .src_page_new(src_page_new), .dst_page_new(dst_page_new)
);

// File: tb/blkcopy_test.sv
module blkcopy_test;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int PB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [LW-1:0] len = '0;
  logic          busy, done, mem_req, mem_we, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;
  logic          src_page_new, dst_page_new;

  always #4 clk = ~clk;

  blkcopy #(.AW(AW), .LW(LW), .PAGE_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .dst(dst), .len(len),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .src_page_new(src_page_new), .dst_page_new(dst_page_new)
  );

  logic [7:0] mem [256];
  logic [7:0] ref_m [256];
  logic [7:0] orig [256];

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        if (mem_wide)
          for (int k = 0; k < 4; k++) mem[8'(int'(mem_addr) + k)] <= mem_wdata[8*k +: 8];
        else mem[mem_addr] <= mem_wdata[7:0];
      end else begin
        if (mem_wide)
          mem_rdata <= {mem[8'(int'(mem_addr) + 3)], mem[8'(int'(mem_addr) + 2)],
                        mem[8'(int'(mem_addr) + 1)], mem[mem_addr]};
        else mem_rdata <= {24'b0, mem[mem_addr]};
      end
    end else mem_ack <= 1'b0;
  end

  int checks = 0, failures = 0;
  int n_rd, n_wr, n_wrd, n_spg, n_dpg, n_alt;
  logic last_rd = 1'b0;

  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        n_wr++;
        if (!last_rd) n_alt++;
        last_rd = 1'b0;
        if (dst_page_new) n_dpg++;
      end else begin
        n_rd++;
        if (mem_wide) n_wrd++;
        if (last_rd) n_alt++;
        last_rd = 1'b1;
        if (src_page_new) n_spg++;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected < 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (src=%0d dst=%0d len=%0d)",
               req, act, exp, src, dst, len);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      orig[i] = mem[i];
      ref_m[i] = mem[i];
    end
  endtask

  function automatic int pages(input int a, input int l);
    if (l == 0) return 0;
    return ((a + l - 1) >> PB) - (a >> PB) + 1;
  endfunction

  task automatic run(input int s, input int d, input int l, input bit poke);
    int exp_w, rs, rd, r, mism, guard;
    init_mem();
    for (int i = 0; i < l; i++) ref_m[8'(d + i)] = ref_m[8'(s + i)];
    exp_w = 0; rs = s; rd = d; r = l;
    while (r > 0) begin
      if (rs % 4 == 0 && rd % 4 == 0 && r >= 4) begin exp_w++; rs += 4; rd += 4; r -= 4; end
      else begin rs++; rd++; r--; end
    end
    n_rd = 0; n_wr = 0; n_wrd = 0; n_spg = 0; n_dpg = 0; n_alt = 0; last_rd = 1'b0;
    @(negedge clk);
    src = AW'(s); dst = AW'(d); len = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (l == 0) begin
      chk(done == 1'b1, "R5 done next cycle", int'(done), 1);
      chk(busy == 1'b0, "R5 busy low", int'(busy), 0);
    end else chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    guard = 0;
    while (!done && guard < 500) begin
      if (poke && guard == 3) begin
        src = AW'(s + 5); dst = AW'(d + 9); len = LW'(7); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    src = AW'(s); dst = AW'(d); len = LW'(l);
    chk(done == 1'b1, "R6 done seen", int'(done), 1);
    chk(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) mism++;
    chk(mism == 0, poke ? "R8 start ignored, memory" : "R1 memory result", mism, 0);
    chk(n_wrd == exp_w, "R3 word accesses", n_wrd, exp_w);
    chk(n_rd == l - 3 * exp_w, "R3 total reads", n_rd, l - 3 * exp_w);
    chk(n_wr == n_rd && n_alt == 0, "R4 read/write pairing", n_wr, n_rd);
    chk(n_spg == pages(s, l), "R7 src pages", n_spg, pages(s, l));
    chk(n_dpg == pages(d, l), "R7 dst pages", n_dpg, pages(d, l));
    if (l == 0) chk(n_rd == 0, "R5 no access", n_rd, 0);
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R9 reset state",
        int'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R9 idle after reset",
        int'({busy, done, mem_req}), 0);

    run(32, 33, 10, 1'b0);
    begin
      int bad = 0;
      for (int i = 33; i < 43; i++) if (mem[i] !== orig[32]) bad++;
      chk(bad == 0, "R2 fill idiom", bad, 0);
    end
    run(40, 24, 11, 1'b1);
    run(36, 44, 9, 1'b1);

    for (int s = 32; s < 40; s++)
      for (int d = 28; d < 44; d++)
        for (int l = 0; l < 12; l++)
          run(s, d, l, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule